// File: doc/BRIEF.md
# Binary-Tree Parallel-to-Serial Converter

The block turns a stream of 16-bit parallel words into a single serial bit stream per channel. It is built as a binary tree of 2:1 multiplexing stages: the word is narrowed to 8 bits, then 4, then 2, and a final half-rate stage drives one bit per clock phase. A counter steps once per fast clock and produces a divide-by-two chain. That chain paces every stage of the tree at its own data rate. It also produces a word-rate clock that is exported to the data source.

The output bit rate is twice the fast clock frequency, and one word is consumed every W/2 fast cycles. Two channels share the single divider chain. Each channel has its own multiplexer tree, so the channels keep the same phase and carry independent data. The data source updates its word in step with the exported word clock, and the block samples the word on the rising edge of that clock.

Top module: `mux_tree_serializer`

## Requirements
- R1: Reset is synchronous and active high on `clk_fast`. During reset, and for the first W fast edges after release, every `ser_out` bit is 0. `word_clk` is 1 while reset is held.
- R2: `word_clk` has a period of W/2 fast cycles. It is high for the W/4 cycles that follow the fast edge capturing a word, and it rises only on that capturing edge.
- R3: `par_in` is sampled only on the fast edge where `word_clk` rises. Any value it holds at other times in the word period has no effect on the serial stream.
- R4: Each word is sent in ascending bit order: bit 0 first and bit W-1 last. Channel c takes its word from `par_in[c*W +: W]` and drives `ser_out[c]`.
- R5: Two bits leave per fast cycle. Stream position 2j is driven during the high phase after a fast edge, and position 2j+1 is driven during the low phase that follows.
- R6: A word captured on fast edge E drives its bit 0 in the high phase after edge E+W/2. Successive words follow each other with no gap or repeated bit.
- R7: Both channels use one divider chain and stay phase-aligned. Each channel's stream depends only on its own slice of `par_in`.
- R8: A reset asserted in the middle of a stream forces the outputs low from the next fast edge. After release, the alignment of R1, R2 and R6 applies again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fastest clock; the serial bit rate is twice its frequency |
| rst | input | 1 | Synchronous active-high reset |
| par_in | input | NCH*W | Parallel words, channel c in bits [c*W +: W] |
| word_clk | output | 1 | Word-rate clock, fast clock divided by W/2, registered |
| ser_out | output | NCH | Serial data, one bit per channel, two bits per fast cycle |

## Verification
Single-bit words such as 0x0001, 0x8000, 0x0002 and 0x0100 locate each bit exactly in time. They separate ascending order from the bit-reversed order that a plain even-first tree would produce, and they expose an off-by-one in latency. The words all-ones, all-zeros, 0xAAAA and 0x5555 are sent back to back. They show whether words join without a gap and whether the high and low phase bits are swapped. Between captures the bench drives the complement of each word, so any sampling outside the capture edge shows up in the stream. Random words on both channels, with different data per channel, catch crossed lanes. A reset in the middle of a stream shows that the outputs clear and that the alignment restarts.

// File: rtl/ser_tree_pkg.sv
package ser_tree_pkg;

  // Reverse the low nbits of idx; used to wire the tree entry so that
  // even-first stages yield an ascending serial order.
  function automatic int unsigned rev_index(input int unsigned idx,
                                            input int unsigned nbits);
    int unsigned r;
    r = 0;
    for (int unsigned b = 0; b < nbits; b++) begin
      r = r | (((idx >> b) & 1) << (nbits - 1 - b));
    end
    return r;
  endfunction

  // Start bit of stage k in the flattened tap vector of a W-bit tree.
  function automatic int unsigned tap_offset(input int unsigned w,
                                             input int unsigned k);
    return 2 * w - 2 * (w >> k);
  endfunction

endpackage

// File: rtl/ser_clk_chain.sv
// Divide-by-two chain built as a binary phase counter on the fast clock.
// Bit i of the counter is the i-th divided clock; stages get enables that
// fire on the fast edge where their divided clock would rise.
module ser_clk_chain #(
  parameter int unsigned CW = 3
) (
  input  logic        clk_fast,
  input  logic        rst,
  output logic        word_clk_o,
  output logic [CW:0] step_en_o,
  output logic [CW:1] slot_o
);

  localparam logic [CW-1:0] HALF = CW'(1) << (CW - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;

  assign cnt_nxt = cnt_q + CW'(1);

  always_ff @(posedge clk_fast) begin
    if (rst) begin
      cnt_q      <= '0;
      word_clk_o <= 1'b1;
    end else begin
      cnt_q      <= cnt_nxt;
      word_clk_o <= ~cnt_nxt[CW-1];
    end
  end

  // Stage k steps when the low CW-k counter bits are all ones.
  always_comb begin
    logic [CW-1:0] mask;
    for (int k = 0; k <= int'(CW); k++) begin
      mask         = {CW{1'b1}} << (CW - k);
      step_en_o[k] = &(cnt_q | mask);
    end
    for (int k = 1; k <= int'(CW); k++) begin
      slot_o[k] = cnt_q[CW-k];
    end
  end

  // R2
  wclk_rise_chk: assert property (@(posedge clk_fast) disable iff (rst)
    $rose(word_clk_o) |-> (cnt_q == '0));

  // R2
  wclk_fall_chk: assert property (@(posedge clk_fast) disable iff (rst)
    $fell(word_clk_o) |-> (cnt_q == HALF));

endmodule

// File: rtl/ser_mux_stage.sv
// One 2:1 narrowing stage: on each enable, output j takes input 2j (slot 0)
// or input 2j+1 (slot 1).
module ser_mux_stage #(
  parameter int unsigned WIN = 16
) (
  input  logic             clk_fast,
  input  logic             rst,
  input  logic             en_i,
  input  logic             slot_i,
  input  logic [WIN-1:0]   d_i,
  output logic [WIN/2-1:0] q_o
);

  localparam int unsigned WOUT = WIN / 2;

  logic [WOUT-1:0] pick;

  always_comb begin
    for (int j = 0; j < int'(WOUT); j++) begin
      pick[j] = slot_i ? d_i[2*j+1] : d_i[2*j];
    end
  end

  always_ff @(posedge clk_fast) begin
    if (rst) begin
      q_o <= '0;
    end else if (en_i) begin
      q_o <= pick;
    end
  end

endmodule

// File: rtl/ser_ddr_out.sv
// Half-rate last stage: two flops capture a bit pair each fast edge, a latch
// holds the second bit through the high phase, and the clock selects which
// stable input reaches the pin.
module ser_ddr_out (
  input  logic       clk_fast,
  input  logic       rst,
  input  logic [1:0] pair_i,
  output logic       ser_o
);

  logic first_q;
  logic second_q;
  logic second_lat;

  always_ff @(posedge clk_fast) begin
    if (rst) begin
      first_q  <= 1'b0;
      second_q <= 1'b0;
    end else begin
      first_q  <= pair_i[0];
      second_q <= pair_i[1];
    end
  end

  always_latch begin
    if (!clk_fast) second_lat = second_q;
  end

  assign ser_o = clk_fast ? first_q : second_lat;

  // R5
  odd_hold_chk: assert property (@(posedge clk_fast) disable iff (rst)
    second_lat == second_q);

endmodule

// File: rtl/ser_lane.sv
// One channel: word register, CW narrowing stages, half-rate output.
module ser_lane
  import ser_tree_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_fast,
  input  logic         rst,
  input  logic [W-1:0] word_i,
  input  logic [$clog2(W)-1:0] en_i,
  input  logic [$clog2(W)-1:1] slot_i,
  output logic         ser_o
);

  localparam int unsigned L    = $clog2(W);
  localparam int unsigned CW   = L - 1;
  localparam int unsigned TAPW = 2 * W - 2;

  logic [W-1:0]    word_nxt;
  logic [W-1:0]    word_q;
  logic [TAPW-1:0] tap;

  // Bit-reversed entry wiring: with even-first stages the stream leaves in
  // ascending bit order.
  always_comb begin
    for (int unsigned i = 0; i < W; i++) begin
      word_nxt[i] = word_i[rev_index(i, L)];
    end
  end

  always_ff @(posedge clk_fast) begin
    if (rst) begin
      word_q <= '0;
    end else if (en_i[0]) begin
      word_q <= word_nxt;
    end
  end

  assign tap[W-1:0] = word_q;

  for (genvar k = 1; k <= CW; k++) begin : g_stage
    localparam int unsigned WIN  = W >> (k - 1);
    localparam int unsigned OIN  = tap_offset(W, k - 1);
    localparam int unsigned OOUT = tap_offset(W, k);
    ser_mux_stage #(.WIN(WIN)) u_stage (
      .clk_fast (clk_fast),
      .rst      (rst),
      .en_i     (en_i[k]),
      .slot_i   (slot_i[k]),
      .d_i      (tap[OIN +: WIN]),
      .q_o      (tap[OOUT +: WIN/2])
    );
  end

  ser_ddr_out u_out (
    .clk_fast (clk_fast),
    .rst      (rst),
    .pair_i   (tap[TAPW-2 +: 2]),
    .ser_o    (ser_o)
  );

endmodule

// File: rtl/mux_tree_serializer.sv
// Multi-channel tree serializer sharing one divider chain. W must be a power
// of two, at least 4.
module mux_tree_serializer #(
  parameter int unsigned W   = 16,
  parameter int unsigned NCH = 2
) (
  input  logic           clk_fast,
  input  logic           rst,
  input  logic [NCH*W-1:0] par_in,
  output logic           word_clk,
  output logic [NCH-1:0] ser_out
);

  localparam int unsigned L     = $clog2(W);
  localparam int unsigned CW    = L - 1;
  localparam int unsigned FILLW = L + 1;
  localparam logic [FILLW-1:0] FILL_END = FILLW'(W);

  logic [CW:0] step_en;
  logic [CW:1] slot;

  ser_clk_chain #(.CW(CW)) u_div (
    .clk_fast   (clk_fast),
    .rst        (rst),
    .word_clk_o (word_clk),
    .step_en_o  (step_en),
    .slot_o     (slot)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ser_lane #(.W(W)) u_lane (
      .clk_fast (clk_fast),
      .rst      (rst),
      .word_i   (par_in[c*W +: W]),
      .en_i     (step_en),
      .slot_i   (slot),
      .ser_o    (ser_out[c])
    );
  end

  // Edges since reset, saturating at the tree fill time.
  logic [FILLW-1:0] fill_q;

  always_ff @(posedge clk_fast) begin
    if (rst) begin
      fill_q <= '0;
    end else if (fill_q != FILL_END) begin
      fill_q <= fill_q + FILLW'(1);
    end
  end

  // R1
  idle_low_chk: assert property (@(posedge clk_fast) disable iff (rst)
    (fill_q != FILL_END) |-> (ser_out == '0));

endmodule

// File: tb/tb_mux_tree_serializer.sv
`timescale 1ns/1ps
module tb_mux_tree_serializer;

  localparam int unsigned W      = 16;
  localparam int unsigned NCH    = 2;
  localparam int          CLK_T  = 8;
  localparam int          P      = W / 2;
  localparam int          NWORDS = 48;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NCH*W-1:0] par_in = '0;
  logic             word_clk;
  logic [NCH-1:0]   ser_out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [W-1:0] words [0:NCH-1][0:NWORDS-1];

  mux_tree_serializer #(.W(W), .NCH(NCH)) dut (
    .clk_fast (clk),
    .rst      (rst),
    .par_in   (par_in),
    .word_clk (word_clk),
    .ser_out  (ser_out)
  );

  always #(CLK_T/2) clk = ~clk;

  task automatic check_val(input string tag, input logic [31:0] act,
                           input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected bit of channel ch after edge n (half 0 = high phase).
  function automatic logic exp_bit(int ch, int base, int n, int half);
    int k;
    int j;
    if (n < 2 * P) return 1'b0;
    k = n / P - 2;
    j = n % P;
    return words[ch][base + k][2*j + half];
  endfunction

  task automatic drive_word(input int idx, input bit invert);
    for (int ch = 0; ch < NCH; ch++) begin
      par_in[ch*W +: W] = invert ? ~words[ch][idx] : words[ch][idx];
    end
  endtask

  task automatic run_stream(input int base, input int nw);
    logic [NCH-1:0] exp_v;
    rst = 1'b1;
    repeat (3) begin
      @(posedge clk); #(CLK_T/4);
      check_val("R1 R8 serial low in reset (high phase)", 32'(ser_out), 32'(0));
      check_val("R1 word_clk high in reset", 32'(word_clk), 32'(1));
      @(negedge clk); #(CLK_T/4);
      check_val("R1 R8 serial low in reset (low phase)", 32'(ser_out), 32'(0));
    end
    drive_word(base, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    for (int n = 1; n < P * (nw + 2); n++) begin
      @(posedge clk); #(CLK_T/4);
      check_val("R2 word_clk phase", 32'(word_clk), 32'((n % P) < (P / 2)));
      for (int ch = 0; ch < NCH; ch++) exp_v[ch] = exp_bit(ch, base, n, 0);
      // R4 R5 R6 R7: even stream position in the high phase
      check_val("R4 R5 R6 R7 high-phase bit", 32'(ser_out), 32'(exp_v));
      // R3: complement right after capture, true word mid-period
      if (n % P == 0 && n / P < nw) drive_word(base + n / P, 1'b1);
      if (n % P == P / 2 && n / P < nw) drive_word(base + n / P, 1'b0);
      @(negedge clk); #(CLK_T/4);
      for (int ch = 0; ch < NCH; ch++) exp_v[ch] = exp_bit(ch, base, n, 1);
      // R3 R5 R6: odd stream position in the low phase
      check_val("R3 R5 R6 low-phase bit", 32'(ser_out), 32'(exp_v));
    end
  endtask

  initial begin
    logic [W-1:0] d0 [0:7];
    logic [W-1:0] d1 [0:7];
    d0 = '{16'h0000, 16'hFFFF, 16'h0001, 16'h8000, 16'h0002, 16'hAAAA, 16'h5555, 16'h00FF};
    d1 = '{16'hFFFF, 16'h0000, 16'h8000, 16'h0001, 16'h0100, 16'h5555, 16'hAAAA, 16'hFF00};
    void'($urandom(32'h5E81A7));
    for (int i = 0; i < NWORDS; i++) begin
      words[0][i] = W'($urandom());
      words[1][i] = W'($urandom());
    end
    for (int i = 0; i < 8; i++) begin
      words[0][i] = d0[i];
      words[1][i] = d1[i];
    end
    words[0][20] = 16'h0100;
    words[1][20] = 16'h0040;
    words[0][21] = 16'h1234;
    words[1][21] = 16'h1234;

    run_stream(0, 20);
    // R8: reset lands while the tree still holds data
    run_stream(20, 24);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_T * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL R6 watchdog expired before stream completed");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule